// File: doc/BRIEF.md
# Sampled Serial Angle Readout Port

This block is the host-facing read port of a shaft-angle tracking converter. It takes a live 12-bit angle word and a live 12-bit speed word from the tracking logic. On a falling edge of a sample strobe it freezes both words into holding registers. A host then fetches one of the two frozen words, either as a 16-bit serial frame or as a 12-bit parallel word.

The serial frame carries the 12 data bits first, MSB first. After them come an echo of the word select, a signal-degradation flag, a tracking-loss flag and an odd-parity bit. A falling edge of the read strobe with chip select low loads the frame and enables the data output. The host's serial clock then walks the frame out one bit per period. A rising edge of the read strobe releases the output and aborts the frame.

All strobes and the serial clock come from outside the chip. Each one passes through a two-flop synchroniser and an edge detector in the system clock domain. The system clock must run at least four times faster than the serial clock.

Top module: `angrd_port`

## Requirements
- R1: While reset is asserted and after it is released, both output enables are low. Both holding registers read as zero until the first sample.
- R2: A falling edge of `sample_i` copies `pos_live_i` and `vel_live_i` into the holding registers. Changes of the live inputs at any other time have no effect on the words that are read out.
- R3: At a read-strobe falling edge, `sel_pos_i` = 1 selects the held position word and `sel_pos_i` = 0 selects the held velocity word. Frame bit 3 echoes the select (1 = position).
- R4: Frame bits 15..4 carry the selected 12-bit word, bit 15 being its MSB. Bit 2 is `deg_i` and bit 1 is `lot_i`, both captured at the read-strobe falling edge.
- R5: Frame bit 0 makes the number of ones in the whole 16-bit frame odd.
- R6: In serial mode, frame bit 15 is on `sdo_o` before the first serial-clock falling edge. Each serial-clock rising edge advances to the next lower bit, so the frame is presented MSB first.
- R7: Once all 16 bits have been shifted, further serial-clock rising edges present 0 on `sdo_o` while the read strobe stays low.
- R8: A rising edge of the read strobe drops both output enables and ends the frame. A later read restarts from bit 15.
- R9: A read-strobe falling edge while `cs_n_i` is high is ignored, and no output is enabled.
- R10: With `par_mode_i` = 1, `par_data_o` carries the selected held word and `par_oe_o` is high only while both chip select and the read strobe are low. `sdo_oe_o` stays low in this mode.
- R11: With `par_mode_i` = 0, `par_oe_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pos_live_i | input | 12 | Live unsigned angle word |
| vel_live_i | input | 12 | Live two's complement speed word |
| deg_i | input | 1 | Signal-degradation flag |
| lot_i | input | 1 | Tracking-loss flag |
| sample_i | input | 1 | Sample strobe; a falling edge freezes both words |
| sel_pos_i | input | 1 | Word select: 1 position, 0 velocity |
| par_mode_i | input | 1 | 1 parallel read, 0 serial read |
| cs_n_i | input | 1 | Active-low chip select |
| rd_n_i | input | 1 | Read strobe / frame enable, active low |
| sclk_i | input | 1 | External serial clock |
| sdo_o | output | 1 | Serial data out, 0 when not enabled |
| sdo_oe_o | output | 1 | Serial output enable (low = released) |
| par_data_o | output | 12 | Parallel data, 0 when not enabled |
| par_oe_o | output | 1 | Parallel output enable (low = bus released) |

## Verification
The assertions watch several properties on every cycle:
- the holding registers change only on a detected sample edge;
- the shift register holds still unless a serial-clock rise or a read-strobe edge arrives;
- every loaded frame has odd parity;
- a read-strobe rise drops the enables;
- a read-strobe fall with chip select high starts no frame.

Other behaviour only the bench scenarios can show:
- the bit order and field placement of the frame against independently computed values;
- zero fill after bit 0;
- restart after an abort;
- the choice between parallel and serial mode;
- that live-input changes after a sample do not reach the host.

// File: rtl/angrd_pkg.sv
package angrd_pkg;
    localparam int DATA_W  = 12;
    localparam int FRAME_W = DATA_W + 4;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              sel;
        logic              deg;
        logic              lot;
        logic              par;
    } frame_t;

    function automatic frame_t make_frame(logic [DATA_W-1:0] w, logic s,
                                          logic d, logic l);
        frame_t f;
        f.data = w;
        f.sel  = s;
        f.deg  = d;
        f.lot  = l;
        f.par  = ~(^{w, s, d, l});
        return f;
    endfunction
endpackage

// File: rtl/angrd_sync.sv
module angrd_sync #(
    parameter int             W   = 4,
    parameter logic [W-1:0]   RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    logic [W-1:0] st1_q, st2_q, prv_q;
    logic [W-1:0] st1_d, st2_d, prv_d;

    always_comb begin
        st1_d = raw_i;
        st2_d = st1_q;
        prv_d = st2_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st1_q <= RST;
            st2_q <= RST;
            prv_q <= RST;
        end else begin
            st1_q <= st1_d;
            st2_q <= st2_d;
            prv_q <= prv_d;
        end
    end

    for (genvar i = 0; i < W; i++) begin : g_edge
        assign lvl_o[i]  = st2_q[i];
        assign rise_o[i] = st2_q[i] & ~prv_q[i];
        assign fall_o[i] = ~st2_q[i] & prv_q[i];
    end
endmodule

// File: rtl/angrd_hold.sv
module angrd_hold
    import angrd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snap_i,
    input  logic [DATA_W-1:0] pos_live_i,
    input  logic [DATA_W-1:0] vel_live_i,
    output logic [DATA_W-1:0] pos_o,
    output logic [DATA_W-1:0] vel_o
);
    typedef struct packed {
        logic [DATA_W-1:0] pos;
        logic [DATA_W-1:0] vel;
    } hold_t;

    hold_t h_d, h_q;

    always_comb begin
        h_d = h_q;
        if (snap_i) begin
            h_d.pos = pos_live_i;
            h_d.vel = vel_live_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end

    assign pos_o = h_q.pos;
    assign vel_o = h_q.vel;

    a_r2_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_i |=> ($stable(pos_o) && $stable(vel_o)));
endmodule

// File: rtl/angrd_frame.sv
module angrd_frame
    import angrd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_fall_i,
    input  logic              rd_rise_i,
    input  logic              sclk_rise_i,
    input  logic              cs_n_i,
    input  logic              par_mode_i,
    input  logic              sel_pos_i,
    input  logic              deg_i,
    input  logic              lot_i,
    input  logic [DATA_W-1:0] pos_i,
    input  logic [DATA_W-1:0] vel_i,
    output logic              sdo_o,
    output logic              sdo_oe_o,
    output logic [DATA_W-1:0] par_data_o,
    output logic              par_oe_o
);
    typedef struct packed {
        logic [FRAME_W-1:0] sh;
        logic [DATA_W-1:0]  word;
        logic               live;
    } fr_t;

    fr_t s_d, s_q;
    logic [DATA_W-1:0] pick;

    always_comb begin
        s_d  = s_q;
        pick = sel_pos_i ? pos_i : vel_i;
        if (rd_rise_i) begin
            s_d.live = 1'b0;
        end else if (rd_fall_i && !cs_n_i) begin
            s_d.sh   = make_frame(pick, sel_pos_i, deg_i, lot_i);
            s_d.word = pick;
            s_d.live = 1'b1;
        end else if (sclk_rise_i && s_q.live && !par_mode_i) begin
            s_d.sh = {s_q.sh[FRAME_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sdo_oe_o   = s_q.live & ~par_mode_i & ~cs_n_i;
    assign sdo_o      = sdo_oe_o & s_q.sh[FRAME_W-1];
    assign par_oe_o   = s_q.live & par_mode_i & ~cs_n_i;
    assign par_data_o = par_oe_o ? s_q.word : '0;

    a_r5_odd_parity: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_fall_i && !cs_n_i && !rd_rise_i) |=> (^s_q.sh));
    a_r6_shift_only_on_clock: assert property (@(posedge clk) disable iff (!rst_n)
        (!sclk_rise_i && !rd_fall_i && !rd_rise_i) |=> $stable(s_q.sh));
    a_r8_release_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        rd_rise_i |=> (!sdo_oe_o && !par_oe_o));
    a_r9_cs_high_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_fall_i && cs_n_i && !s_q.live) |=> !s_q.live);
endmodule

// File: rtl/angrd_port.sv
module angrd_port
    import angrd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] pos_live_i,
    input  logic [DATA_W-1:0] vel_live_i,
    input  logic              deg_i,
    input  logic              lot_i,
    input  logic              sample_i,
    input  logic              sel_pos_i,
    input  logic              par_mode_i,
    input  logic              cs_n_i,
    input  logic              rd_n_i,
    input  logic              sclk_i,
    output logic              sdo_o,
    output logic              sdo_oe_o,
    output logic [DATA_W-1:0] par_data_o,
    output logic              par_oe_o
);
    // Synchronised lines: [3] sample, [2] sclk, [1] cs_n, [0] rd_n
    localparam int          NSYNC   = 4;
    localparam logic [3:0]  IDLE_LV = 4'b0111;

    logic [NSYNC-1:0] lvl, rise, fall;
    logic [DATA_W-1:0] pos_h, vel_h;

    angrd_sync #(.W(NSYNC), .RST(IDLE_LV)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  ({sample_i, sclk_i, cs_n_i, rd_n_i}),
        .lvl_o  (lvl),
        .rise_o (rise),
        .fall_o (fall)
    );

    angrd_hold u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .snap_i     (fall[3]),
        .pos_live_i (pos_live_i),
        .vel_live_i (vel_live_i),
        .pos_o      (pos_h),
        .vel_o      (vel_h)
    );

    angrd_frame u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_fall_i   (fall[0]),
        .rd_rise_i   (rise[0]),
        .sclk_rise_i (rise[2]),
        .cs_n_i      (lvl[1]),
        .par_mode_i  (par_mode_i),
        .sel_pos_i   (sel_pos_i),
        .deg_i       (deg_i),
        .lot_i       (lot_i),
        .pos_i       (pos_h),
        .vel_i       (vel_h),
        .sdo_o       (sdo_o),
        .sdo_oe_o    (sdo_oe_o),
        .par_data_o  (par_data_o),
        .par_oe_o    (par_oe_o)
    );

    a_r10_single_driver: assert property (@(posedge clk) disable iff (!rst_n)
        !(sdo_oe_o && par_oe_o));
endmodule

// File: tb/angrd_port_test.sv
module angrd_port_test;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [11:0] pos_live = 0, vel_live = 0;
    logic        deg = 0, lot = 0, sample = 0, sel_pos = 1, par_mode = 0;
    logic        cs_n = 1, rd_n = 1, sclk = 1;
    logic        sdo, sdo_oe, par_oe;
    logic [11:0] par_data;

    int checks = 0, failures = 0;

    always #10 clk = ~clk;

    angrd_port uut (
        .clk(clk), .rst_n(rst_n), .pos_live_i(pos_live), .vel_live_i(vel_live),
        .deg_i(deg), .lot_i(lot), .sample_i(sample), .sel_pos_i(sel_pos),
        .par_mode_i(par_mode), .cs_n_i(cs_n), .rd_n_i(rd_n), .sclk_i(sclk),
        .sdo_o(sdo), .sdo_oe_o(sdo_oe), .par_data_o(par_data), .par_oe_o(par_oe)
    );

    // {pos, vel, sel, deg, lot}
    localparam int NV = 6;
    localparam logic [26:0] VEC [NV] = '{
        {12'h000, 12'h000, 1'b1, 1'b0, 1'b0},
        {12'hFFF, 12'h801, 1'b0, 1'b1, 1'b1},
        {12'hA5C, 12'h7FF, 1'b1, 1'b1, 1'b0},
        {12'h123, 12'hF00, 1'b0, 1'b0, 1'b1},
        {12'hFFF, 12'h000, 1'b1, 1'b1, 1'b1},
        {12'h3C0, 12'h001, 1'b0, 1'b0, 1'b0}
    };

    task automatic wt(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_frame(logic [11:0] w, logic s, logic d, logic l);
        logic [15:0] f = {w, s, d, l, 1'b0};
        int ones = 0;
        for (int i = 1; i < 16; i++) ones += f[i];
        f[0] = (ones % 2 == 0);
        return f;
    endfunction

    task automatic snap();
        sample = 1; wt(5);
        sample = 0; wt(5);
    endtask

    task automatic read_serial(logic [15:0] f, int nbits, string req);
        for (int i = 0; i < nbits; i++) begin
            sclk = 0; wt(5);
            chk(sdo === (i < 16 ? f[15-i] : 1'b0),
                (i < 16) ? req : "R7 zero fill", int'(sdo), int'(i < 16 ? f[15-i] : 1'b0));
            sclk = 1; wt(5);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
        $finish;
    end

    initial begin
        logic [11:0] p, v;
        logic s, d, l;
        wt(3);
        chk(!sdo_oe && !par_oe, "R1 enables in reset", {sdo_oe, par_oe}, 0);
        rst_n = 1; wt(3);
        chk(!sdo_oe && !par_oe, "R1 enables after reset", {sdo_oe, par_oe}, 0);

        // R1: holding registers zero before any sample
        cs_n = 0; sel_pos = 1; rd_n = 0; wt(5);
        read_serial(exp_frame(12'h000, 1, 0, 0), 16, "R1 held zero");
        rd_n = 1; wt(5);

        // Vector table: R2 R3 R4 R5 R6 R7 R8 R11
        for (int k = 0; k < NV; k++) begin
            {p, v, s, d, l} = VEC[k];
            pos_live = p; vel_live = v; wt(2);
            snap();
            pos_live = ~p; vel_live = ~v;  // R2: must not be seen
            sel_pos = s; deg = d; lot = l; wt(2);
            rd_n = 0; wt(5);
            chk(sdo_oe === 1'b1, "R6 serial enable", int'(sdo_oe), 1);
            chk(par_oe === 1'b0, "R11 parallel off in serial", int'(par_oe), 0);
            read_serial(exp_frame(s ? p : v, s, d, l), 18, "R3 R4 R5 R6 frame bit");
            rd_n = 1; wt(5);
            chk(sdo_oe === 1'b0, "R8 release", int'(sdo_oe), 0);
        end

        // R9: chip select high ignores read
        {p, v, s, d, l} = VEC[2];
        pos_live = p; vel_live = v; wt(2); snap();
        sel_pos = 1; deg = 0; lot = 0;
        cs_n = 1; wt(5);
        rd_n = 0; wt(5);
        chk(!sdo_oe && !par_oe, "R9 cs high read", {sdo_oe, par_oe}, 0);
        rd_n = 1; wt(5);
        cs_n = 0; wt(5);

        // R8: abort mid-frame, next read restarts at bit 15
        rd_n = 0; wt(5);
        read_serial(exp_frame(p, 1, 0, 0), 3, "R8 partial");
        rd_n = 1; wt(5);
        chk(sdo_oe === 1'b0, "R8 abort release", int'(sdo_oe), 0);
        rd_n = 0; wt(5);
        read_serial(exp_frame(p, 1, 0, 0), 16, "R8 restart");
        rd_n = 1; wt(5);

        // R10: parallel mode
        par_mode = 1; wt(2);
        chk(par_oe === 1'b0, "R10 idle bus", int'(par_oe), 0);
        sel_pos = 1; rd_n = 0; wt(5);
        chk(par_oe === 1'b1, "R10 enable", int'(par_oe), 1);
        chk(par_data === p, "R10 position word", par_data, p);
        chk(sdo_oe === 1'b0, "R10 serial off", int'(sdo_oe), 0);
        cs_n = 1; wt(5);
        chk(par_oe === 1'b0, "R10 cs high releases", int'(par_oe), 0);
        cs_n = 0; wt(5);
        rd_n = 1; wt(5);
        chk(par_oe === 1'b0, "R10 rd high releases", int'(par_oe), 0);
        sel_pos = 0; rd_n = 0; wt(5);
        chk(par_data === v, "R10 velocity word", par_data, v);
        rd_n = 1; wt(5);
        chk(par_oe === 1'b0, "R10 release", int'(par_oe), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule